// File: doc/BRIEF.md
# I2C Target Register Interface

This block is the control-port front end of a larger device. It sits on a two-wire open-drain bus as a target only. It samples SCL and SDA with a fast system clock and recognises start, repeated start and stop conditions. When its own 7-bit address is called, it opens a register map. The register map has two areas. Subaddresses below 0x20 are byte-wide registers that can be reached one byte at a time. Subaddresses from 0x20 upward are 32-bit registers that are only ever transferred as whole four-byte words, most significant byte first.

A write transfer carries the address byte, then one subaddress byte, then any number of data bytes. The pointer moves forward after each low-area byte and after each complete high-area word. A read first sets the pointer with a short write. The controller then issues a repeated start with the read bit set and clocks out bytes until it answers with a NACK. A strap input picks one of two base addresses. A two-step guarded write can replace that address at run time. The block pulls SDA low only, to acknowledge and to send read data. It never holds SCL.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the SDA pull-down is off and every register reads back as zero.
- R2: With the strap input high the target answers 7-bit address 0x1B. With the strap input low it answers 0x1A. Any other address gets no acknowledge, and SDA is left alone for the rest of that transfer.
- R3: In a write transfer to a matching address, the address byte, the subaddress byte and every data byte are acknowledged: SDA is held low through the ninth SCL clock.
- R4: A single data byte written to a subaddress in 0x00..0x1F is stored. A read that sets the pointer to that subaddress and then uses a repeated start returns that byte.
- R5: In the low area, successive data bytes of one transfer go to consecutive subaddresses, for writes and for reads.
- R6: A subaddress of 0x20 or above holds a 32-bit word, transferred most significant byte first. A write stores the word only when its fourth byte is received. The pointer then moves to the next subaddress, so eight bytes fill two consecutive words. Reads walk through the words in the same way.
- R7: An incomplete high-area word is dropped without changing the register when the transfer ends in a stop or a repeated start. A new start also resets the byte position to the first byte of a word.
- R8: After the controller answers a read byte with NACK, the target stops driving SDA and waits for the next start or stop.
- R9: Writing the word 0xF9A5A5A5 to subaddress 0xF8 arms an address change. If the next word write goes to subaddress 0xF9 with value 0x000000XX, the target from then on answers only the 7-bit address XX[7:1], that is, XX read as the 8-bit write form.
- R10: A word write to 0xF9 changes nothing if the last committed word before it was not the exact unlock value written to 0xF8. A wrong value at 0xF8 counts, and so does any other word write in between.
- R11: The target changes its SDA drive only while SCL is low, and it has no way to drive SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| addr_sel | input | 1 | Address strap: 0 selects 0x1A, 1 selects 0x1B |
| sda_oe | output | 1 | When high, pull the data line low |

## Verification
The assertions assume that the controller moves SDA only while SCL is low, except for start and stop conditions. They also assume that every bus level is held longer than the two-flop synchroniser plus the glitch filter, and that the strap input changes only between transfers. The bench's bus model builds every bit from quarter periods of 20 system clocks. SDA is changed only in the quarter after SCL has fallen, and the model releases SDA whenever the target is due to drive it. These conditions keep the bus within what the properties take for granted.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int unsigned   SUB_W      = 8;
    localparam int unsigned   LO_REGS    = 32;
    localparam int unsigned   HI_WORDS   = 8;
    localparam logic [7:0]    HI_BASE    = 8'h20;
    localparam logic [7:0]    KEY_SUB    = 8'hF8;
    localparam logic [7:0]    NEWADR_SUB = 8'hF9;
    localparam logic [31:0]   KEY_WORD   = 32'hF9A5_A5A5;
    localparam logic [5:0]    STRAP_BASE = 6'b001101;

    typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_ACK_OUT, PH_TX, PH_ACK_IN} phase_e;
    typedef enum logic [1:0] {BY_ADDR, BY_SUB, BY_DATA} role_e;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [1:0]       idx;
    } ptr_t;

    typedef struct packed {
        logic             valid;
        logic [SUB_W-1:0] sub;
        logic [7:0]       data;
    } byte_wr_t;

    typedef struct packed {
        logic             valid;
        logic [SUB_W-1:0] sub;
        logic [31:0]      data;
    } word_wr_t;

    function automatic logic in_low(input logic [SUB_W-1:0] sub);
        return sub < SUB_W'(LO_REGS);
    endfunction

    // one step of the register pointer: per byte low, per word high
    function automatic ptr_t ptr_step(input ptr_t p);
        ptr_t n;
        n = p;
        if (in_low(p.sub)) begin
            n.sub = p.sub + 1'b1;
        end else if (p.idx == 2'd3) begin
            n.sub = p.sub + 1'b1;
            n.idx = 2'd0;
        end else begin
            n.idx = p.idx + 2'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int unsigned STABLE_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (sync_q[1] == dout) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
                dout  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned LO_N   = LO_REGS,
    parameter int unsigned HI_N   = HI_WORDS,
    parameter logic [7:0]  HI_ORG = HI_BASE
) (
    input  logic       clk,
    input  logic       rst,
    input  byte_wr_t   bwr,
    input  word_wr_t   wwr,
    input  logic [7:0] rd_sub,
    input  logic [1:0] rd_idx,
    output logic [7:0] rd_byte
);
    localparam int unsigned LW = $clog2(LO_N);
    localparam int unsigned HW = $clog2(HI_N);

    logic [7:0]  lo_q [LO_N];
    logic [31:0] hi_q [HI_N];
    logic [7:0]  w_off, r_off;
    logic        w_hit, r_hit;
    logic [31:0] r_word;

    always_comb begin
        w_off = wwr.sub - HI_ORG;
        r_off = rd_sub - HI_ORG;
        w_hit = (wwr.sub >= HI_ORG) && (w_off < 8'(HI_N));
        r_hit = (rd_sub >= HI_ORG) && (r_off < 8'(HI_N));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LO_N; i++) lo_q[i] <= '0;
            for (int j = 0; j < HI_N; j++) hi_q[j] <= '0;
        end else begin
            if (bwr.valid && (bwr.sub < 8'(LO_N)))
                lo_q[bwr.sub[LW-1:0]] <= bwr.data;
            if (wwr.valid && w_hit)
                hi_q[w_off[HW-1:0]] <= wwr.data;
        end
    end

    always_comb begin
        r_word  = r_hit ? hi_q[r_off[HW-1:0]] : '0;
        rd_byte = 8'h00;
        if (rd_sub < 8'(LO_N)) begin
            rd_byte = lo_q[rd_sub[LW-1:0]];
        end else begin
            case (rd_idx)
                2'd0:    rd_byte = r_word[31:24];
                2'd1:    rd_byte = r_word[23:16];
                2'd2:    rd_byte = r_word[15:8];
                default: rd_byte = r_word[7:0];
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_unit.sv
module i2c_addr_unit
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strap,
    input  word_wr_t   wwr,
    output logic [6:0] dev_addr
);
    logic       armed_q, ovr_q;
    logic [6:0] ovr_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            ovr_q      <= 1'b0;
            ovr_addr_q <= '0;
        end else if (wwr.valid) begin
            // any committed word re-evaluates the unlock state
            armed_q <= (wwr.sub == KEY_SUB) && (wwr.data == KEY_WORD);
            if (armed_q && (wwr.sub == NEWADR_SUB)) begin
                ovr_q      <= 1'b1;
                ovr_addr_q <= wwr.data[7:1];
            end
        end
    end

    assign dev_addr = ovr_q ? ovr_addr_q : {STRAP_BASE, strap};
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_byte,
    output logic [7:0] rd_sub,
    output logic [1:0] rd_idx,
    output byte_wr_t   bwr,
    output word_wr_t   wwr,
    output logic       sda_oe
);
    phase_e      phase;
    role_e       role;
    ptr_t        ptr;
    logic        rw, nack_q, scl_q, sda_q;
    logic [3:0]  bitc;
    logic [7:0]  shreg, txb;
    logic [23:0] hold;

    wire scl_rise = scl_f & ~scl_q;
    wire scl_fall = ~scl_f & scl_q;
    wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
    wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

    assign rd_sub = ptr.sub;
    assign rd_idx = ptr.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            role   <= BY_ADDR;
            ptr    <= '0;
            rw     <= 1'b0;
            nack_q <= 1'b0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            bitc   <= '0;
            shreg  <= '0;
            txb    <= '0;
            hold   <= '0;
            bwr    <= '0;
            wwr    <= '0;
            sda_oe <= 1'b0;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            bwr.valid <= 1'b0;
            wwr.valid <= 1'b0;
            if (start_c) begin
                phase   <= PH_RX;
                role    <= BY_ADDR;
                bitc    <= '0;
                ptr.idx <= 2'd0;
                sda_oe  <= 1'b0;
            end else if (stop_c) begin
                phase   <= PH_IDLE;
                ptr.idx <= 2'd0;
                sda_oe  <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_f};
                            bitc  <= bitc + 1'b1;
                        end else if (scl_fall && (bitc == 4'd8)) begin
                            bitc <= '0;
                            case (role)
                                BY_ADDR: begin
                                    if (shreg[7:1] == dev_addr) begin
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        phase  <= PH_ACK_OUT;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                BY_SUB: begin
                                    ptr    <= '{sub: shreg, idx: 2'd0};
                                    role   <= BY_DATA;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK_OUT;
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK_OUT;
                                    ptr    <= ptr_step(ptr);
                                    if (in_low(ptr.sub))
                                        bwr <= '{valid: 1'b1, sub: ptr.sub, data: shreg};
                                    else if (ptr.idx == 2'd3)
                                        wwr <= '{valid: 1'b1, sub: ptr.sub, data: {hold, shreg}};
                                    else
                                        hold <= {hold[15:0], shreg};
                                end
                            endcase
                        end
                    end
                    PH_ACK_OUT: begin
                        if (scl_fall) begin
                            if (rw && (role == BY_ADDR)) begin
                                txb    <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                bitc   <= 4'd1;
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                                if (role == BY_ADDR) role <= BY_SUB;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_fall) begin
                            if (bitc == 4'd8) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr_step(ptr);
                                phase  <= PH_ACK_IN;
                            end else begin
                                sda_oe <= ~txb[3'(4'd7 - bitc)];
                                bitc   <= bitc + 1'b1;
                            end
                        end
                    end
                    PH_ACK_IN: begin
                        if (scl_rise) begin
                            nack_q <= sda_f;
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                phase <= PH_IDLE;
                            end else begin
                                txb    <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                bitc   <= 4'd1;
                                phase  <= PH_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned FILT_CYC = 3,
    parameter int unsigned HI_N     = HI_WORDS
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    output logic sda_oe
);
    logic [1:0] raw_l, flt_l;
    logic [6:0] dev_addr;
    logic [7:0] rd_byte, rd_sub;
    logic [1:0] rd_idx;
    byte_wr_t   bwr;
    word_wr_t   wwr;

    assign raw_l = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_l[g]),
            .dout (flt_l[g])
        );
    end

    i2c_bus_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (flt_l[1]),
        .sda_f    (flt_l[0]),
        .dev_addr (dev_addr),
        .rd_byte  (rd_byte),
        .rd_sub   (rd_sub),
        .rd_idx   (rd_idx),
        .bwr      (bwr),
        .wwr      (wwr),
        .sda_oe   (sda_oe)
    );

    i2c_reg_bank #(.LO_N(LO_REGS), .HI_N(HI_N), .HI_ORG(HI_BASE)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .bwr     (bwr),
        .wwr     (wwr),
        .rd_sub  (rd_sub),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

    i2c_addr_unit u_addr (
        .clk      (clk),
        .rst      (rst),
        .strap    (addr_sel),
        .wwr      (wwr),
        .dev_addr (dev_addr)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       addr_sel,
    input logic [6:0] dev_addr,
    input byte_wr_t   bwr,
    input word_wr_t   wwr
);
    // R1: the cycle after reset the pull-down is off
    p_reset_release_r1: assert property (@(posedge clk) $past(rst) |-> !sda_oe);

    // R11: drive changes only with the clock line low
    p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    // R4: never a byte and a word store in the same cycle
    p_one_store_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bwr.valid, wwr.valid}));

    // R6: word stores only target the high area
    p_word_high_r6: assert property (@(posedge clk) disable iff (rst)
        wwr.valid |-> !in_low(wwr.sub));

    // R5: byte stores only target the low area
    p_byte_low_r5: assert property (@(posedge clk) disable iff (rst)
        bwr.valid |-> in_low(bwr.sub));

    // R9: the answered address moves only by strap or by a store to the change register
    p_addr_source_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(dev_addr) |-> (!$stable(addr_sel) || $past(wwr.valid && (wwr.sub == NEWADR_SUB))));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .addr_sel (addr_sel),
    .dev_addr (dev_addr),
    .bwr      (bwr),
    .wwr      (wwr)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
    localparam int          Q     = 20;
    localparam logic [6:0]  A_LO  = 7'h1A;
    localparam logic [6:0]  A_HI  = 7'h1B;
    localparam logic [6:0]  A_NEW = 7'h20;
    localparam int          NV    = 6;
    // {subaddress, data} pairs for single-byte low-area round trips
    localparam logic [15:0] VEC [NV] = '{16'h00A5, 16'h1F3C, 16'h07FF,
                                         16'h0881, 16'h155A, 16'h1EC3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic last_oe = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    int n_chk = 0;
    int n_err = 0;
    int hi_chg = 0;
    logic oe_prev = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5ns clk = ~clk;

    i2c_reg_target u_i2c_reg_target (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .addr_sel (addr_sel),
        .sda_oe   (sda_oe)
    );

    // R11 monitor: count drive changes seen while SCL is high
    always @(posedge clk) begin
        #1ns;
        if (!rst && (sda_oe !== oe_prev) && scl_m) hi_chg++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; hq();
        scl_m = 1'b1; hq(); hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        b = sda_bus; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic nack);
        logic b;
        logic [7:0] t;
        t = '0;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            t[i] = b;
        end
        wbit(nack);
        d = t;
    endtask

    task automatic probe(input logic [6:0] a, output logic ack);
        bus_start();
        wbyte({a, 1'b0}, ack);
        bus_stop();
    endtask

    task automatic wr_regs(input logic [6:0] a, input logic [7:0] s, input int n, output logic ok);
        logic k;
        ok = 1'b1;
        bus_start();
        wbyte({a, 1'b0}, k); ok = ok & k;
        wbyte(s, k);         ok = ok & k;
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], k);
            ok = ok & k;
        end
        bus_stop();
    endtask

    task automatic rd_regs(input logic [6:0] a, input logic [7:0] s, input int n, output logic ok);
        logic k;
        logic [7:0] d;
        ok = 1'b1;
        bus_start();
        wbyte({a, 1'b0}, k); ok = ok & k;
        wbyte(s, k);         ok = ok & k;
        bus_start();
        wbyte({a, 1'b1}, k); ok = ok & k;
        for (int i = 0; i < n; i++) begin
            rbyte(d, i == n - 1);
            rbuf[i] = d;
        end
        last_oe = sda_oe;
        bus_stop();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic k;
        logic ok;
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 drive off after reset", 32'(sda_oe), 32'd0);
        rd_regs(A_HI, 8'h05, 1, ok);
        chk("R1 register reset value", 32'(rbuf[0]), 32'h00);

        // R2 strap selection
        probe(A_HI, k);
        chk("R2 strap high answers 0x1B", 32'(k), 32'd1);
        probe(A_LO, k);
        chk("R2 strap high ignores 0x1A", 32'(k), 32'd0);
        addr_sel = 1'b0;
        repeat (4) @(negedge clk);
        probe(A_LO, k);
        chk("R2 strap low answers 0x1A", 32'(k), 32'd1);
        probe(A_HI, k);
        chk("R2 strap low ignores 0x1B", 32'(k), 32'd0);

        // R3/R4 vector table walk
        for (int v = 0; v < NV; v++) begin
            wbuf[0] = VEC[v][7:0];
            wr_regs(A_LO, VEC[v][15:8], 1, ok);
            chk("R3 write acknowledged", 32'(ok), 32'd1);
            rd_regs(A_LO, VEC[v][15:8], 1, ok);
            chk("R4 byte read back", 32'(rbuf[0]), 32'(VEC[v][7:0]));
        end

        // R5 low-area auto increment
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_regs(A_LO, 8'h10, 3, ok);
        chk("R3 multi-byte write acknowledged", 32'(ok), 32'd1);
        rd_regs(A_LO, 8'h10, 3, ok);
        chk("R5 burst byte 0", 32'(rbuf[0]), 32'h11);
        chk("R5 burst byte 1", 32'(rbuf[1]), 32'h22);
        chk("R5 burst byte 2", 32'(rbuf[2]), 32'h33);
        rd_regs(A_LO, 8'h11, 1, ok);
        chk("R5 second register alone", 32'(rbuf[0]), 32'h22);

        // R6 high-area words
        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
        wbuf[4] = 8'h12; wbuf[5] = 8'h34; wbuf[6] = 8'h56; wbuf[7] = 8'h78;
        wr_regs(A_LO, 8'h20, 8, ok);
        rd_regs(A_LO, 8'h20, 8, ok);
        chk("R6 two-word read first word",
            {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'hDEADBEEF);
        chk("R6 two-word read second word",
            {rbuf[4], rbuf[5], rbuf[6], rbuf[7]}, 32'h12345678);
        rd_regs(A_LO, 8'h21, 4, ok);
        chk("R6 second word direct", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h12345678);

        // R7 partial word at stop
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        wr_regs(A_LO, 8'h22, 2, ok);
        rd_regs(A_LO, 8'h22, 4, ok);
        chk("R7 partial word dropped at stop", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h0);

        // R7 partial word at repeated start, read restarts at first byte
        bus_start();
        wbyte({A_LO, 1'b0}, k);
        wbyte(8'h23, k);
        wbyte(8'hCC, k); wbyte(8'hDD, k); wbyte(8'hEE, k);
        bus_start();
        wbyte({A_LO, 1'b1}, k);
        for (int i = 0; i < 4; i++) rbyte(rbuf[i], i == 3);
        last_oe = sda_oe;
        bus_stop();
        chk("R7 partial word dropped at restart", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h0);

        // R8 drive released after NACK (next byte would start with a low bit)
        chk("R8 drive off after NACK", 32'(last_oe), 32'd0);
        chk("R8 bus high after stop", 32'(sda_bus), 32'd1);

        // R10 wrong unlock value
        wbuf[0] = 8'hF9; wbuf[1] = 8'hA5; wbuf[2] = 8'hA5; wbuf[3] = 8'hA4;
        wr_regs(A_LO, 8'hF8, 4, ok);
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wbuf[3] = 8'h40;
        wr_regs(A_LO, 8'hF9, 4, ok);
        probe(A_LO, k);
        chk("R10 wrong key keeps old address", 32'(k), 32'd1);
        probe(A_NEW, k);
        chk("R10 wrong key new address unused", 32'(k), 32'd0);

        // R10 correct key but an intervening word write
        wbuf[0] = 8'hF9; wbuf[1] = 8'hA5; wbuf[2] = 8'hA5; wbuf[3] = 8'hA5;
        wr_regs(A_LO, 8'hF8, 4, ok);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        wr_regs(A_LO, 8'h24, 4, ok);
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wbuf[3] = 8'h40;
        wr_regs(A_LO, 8'hF9, 4, ok);
        probe(A_LO, k);
        chk("R10 intervening write disarms", 32'(k), 32'd1);

        // R9 proper change sequence
        wbuf[0] = 8'hF9; wbuf[1] = 8'hA5; wbuf[2] = 8'hA5; wbuf[3] = 8'hA5;
        wr_regs(A_LO, 8'hF8, 4, ok);
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wbuf[3] = 8'h40;
        wr_regs(A_LO, 8'hF9, 4, ok);
        probe(A_NEW, k);
        chk("R9 new address answered", 32'(k), 32'd1);
        probe(A_LO, k);
        chk("R9 old address ignored", 32'(k), 32'd0);
        rd_regs(A_NEW, 8'h20, 4, ok);
        chk("R9 read through new address", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'hDEADBEEF);

        // R11 no drive change with SCL high
        chk("R11 drive changes while SCL high", 32'(hi_chg), 32'd0);

        summary();
        $finish;
    end
endmodule